// File: doc/BRIEF.md
# PLL Divider Search Engine

This block works out the divider settings for a PHY PLL. Software or a configuration sequencer presents a reference clock frequency and a target line rate, both as whole numbers of MHz, and pulses `start`. The engine then walks through every allowed input pre-divider value. For each one it divides the scaled target by the reference and keeps the candidate whose division leaves the smallest remainder, provided the feedback divider it implies stays below 512.

The pre-divider window keeps the phase detector input between 5 MHz and 40 MHz. If that window is empty, the engine raises an error instead of searching. When the search finishes, the engine derives the feedback divider from the winning pre-divider and computes the rate the PLL will actually reach. It also packs the results into the three byte-wide codes a PHY configuration sequence expects.

All quotients and remainders come from one shared bit-serial restoring divider. A search therefore costs one divider pass per candidate plus two more passes, for the feedback divider and for the achieved rate.

Top module: `pll_divider_search`

## Requirements
- R1: The pre-divider window is computed from the latched reference `F`. Its upper bound is `floor(F/5)`. Its lower bound is 1 when `F < 40`, and `floor(F/40)+1` otherwise.
- R2: If the upper bound is below the lower bound (for example F = 4 or F = 0), the run ends with `done`=1 and `err`=1. In that case `prediv_val`, `fbdiv_val`, `achieved_mhz` and all three codes are 0.
- R3: Candidates i run from the lower bound up to, but excluding, the upper bound. A candidate replaces the current best only when `(T*i) mod F` is strictly smaller than the best remainder so far and `floor(T*i/F) < 512`. The best remainder starts at F. On a tie, the smaller i is kept.
- R4: When no candidate is accepted, including when the window holds no value, the pre-divider is 1.
- R5: `fbdiv_val = floor(T*P/F)` and `achieved_mhz = floor(F*fbdiv_val/P)`, where P is the chosen pre-divider.
- R6: The codes are computed with `fbdiv_val-1` taken modulo 2^(2*FW):
  - `prediv_code` is the low 8 bits of P-1.
  - `fb_lo_code` holds the low 5 bits of `fbdiv_val-1` in bits 4:0, with bits 7:5 zero.
  - `fb_hi_code` is 0x80 ORed with bits 12:5 of `fbdiv_val-1`.
- R7: A `start` pulse while idle latches both inputs. `busy` is high from the next cycle until the run ends. On the cycle `busy` falls, `done` rises. `done` and every result then hold until the next accepted `start`. A `start` while busy, and input changes after the launch, have no effect on the result.
- R8: After reset, `busy`, `done`, `err` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| ref_mhz | input | FW | Reference clock in MHz |
| target_mhz | input | FW | Target PHY rate in MHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | Results valid; held until the next launch |
| err | output | 1 | Empty pre-divider window; valid with `done` |
| prediv_val | output | FW | Chosen pre-divider |
| fbdiv_val | output | 2*FW | Feedback divider |
| achieved_mhz | output | 3*FW | Rate the PLL reaches with these dividers |
| prediv_code | output | 8 | Pre-divider register byte |
| fb_lo_code | output | 8 | Feedback divider low byte |
| fb_hi_code | output | 8 | Feedback divider high byte, flag bit set |

## Verification
Each pattern is aimed at telling two possible behaviours apart.

- An exact-division case (24, 1000) separates a search that finds the zero remainder late in the window from one that stops early.
- The pattern (30, 30) gives every candidate a zero remainder, which shows whether ties keep the smaller pre-divider.
- The pattern (15, 4000) gives a smaller remainder that sits behind the 512 quotient limit.
- References 4 and 5 straddle the empty-window boundary.
- A large reference with a tiny target drives the feedback divider to 0 and forces the wrapped codes.
- Seeded pseudo-random pairs cover the general arithmetic.
- A start pulse and input changes injected mid-run show whether the latched operands stay fixed.

// File: rtl/pds_pkg.sv
package pds_pkg;

  // Phase-detector input frequency bounds in MHz
  localparam int unsigned PFD_LO_MHZ = 5;
  localparam int unsigned PFD_HI_MHZ = 40;

  // Feedback divider must stay strictly below this value
  localparam int unsigned FB_LIMIT = 512;

  // Flag bit set in the high feedback byte
  localparam logic [7:0] HI_FLAG = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_SCAN,
    ST_SWAIT,
    ST_FWAIT,
    ST_AWAIT,
    ST_FIN
  } pds_state_e;

endpackage

// File: rtl/pds_iter_div.sv
// Bit-serial restoring divider: one quotient bit per clock.
module pds_iter_div #(
  parameter int N_W = 36,
  parameter int D_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           valid,
  output logic [N_W-1:0] quo,
  output logic [D_W-1:0] rem
);

  localparam int CNT_W = $clog2(N_W + 1);

  logic [N_W-1:0]   q_r;
  logic [D_W-1:0]   r_r;
  logic [D_W-1:0]   dv_r;
  logic [CNT_W-1:0] cnt_r;
  logic             run_r;
  logic             valid_r;

  logic [D_W:0]   shifted;
  logic [D_W:0]   diff;
  logic           ge;
  logic [D_W-1:0] r_nxt;
  logic [N_W-1:0] q_nxt;

  always_comb begin
    shifted = {r_r, q_r[N_W-1]};
    ge      = shifted >= {1'b0, dv_r};
    diff    = shifted - {1'b0, dv_r};
    r_nxt   = ge ? diff[D_W-1:0] : shifted[D_W-1:0];
    q_nxt   = {q_r[N_W-2:0], ge};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r     <= '0;
      r_r     <= '0;
      dv_r    <= '0;
      cnt_r   <= '0;
      run_r   <= 1'b0;
      valid_r <= 1'b0;
    end else if (go) begin
      q_r     <= dividend;
      r_r     <= '0;
      dv_r    <= divisor;
      cnt_r   <= CNT_W'(N_W);
      run_r   <= 1'b1;
      valid_r <= 1'b0;
    end else if (run_r) begin
      q_r   <= q_nxt;
      r_r   <= r_nxt;
      cnt_r <= cnt_r - CNT_W'(1);
      if (cnt_r == CNT_W'(1)) begin
        run_r   <= 1'b0;
        valid_r <= 1'b1;
      end
    end else begin
      valid_r <= 1'b0;
    end
  end

  assign valid = valid_r;
  assign quo   = q_r;
  assign rem   = r_r;

endmodule

// File: rtl/pds_window.sv
// Allowed pre-divider window for a given reference frequency.
module pds_window
  import pds_pkg::*;
#(
  parameter int FW = 12
) (
  input  logic [FW-1:0] ref_in,
  output logic [FW-1:0] pre_lo,
  output logic [FW-1:0] pre_hi,
  output logic          bad
);

  function automatic logic [FW-1:0] f_upper(input logic [FW-1:0] r);
    return r / FW'(PFD_LO_MHZ);
  endfunction

  function automatic logic [FW-1:0] f_lower(input logic [FW-1:0] r);
    if (r >= FW'(PFD_HI_MHZ)) return r / FW'(PFD_HI_MHZ) + FW'(1);
    return FW'(1);
  endfunction

  always_comb begin
    pre_hi = f_upper(ref_in);
    pre_lo = f_lower(ref_in);
    bad    = pre_hi < pre_lo;
  end

endmodule

// File: rtl/pds_judge.sv
// Decides whether a candidate beats the best so far.
module pds_judge
  import pds_pkg::*;
#(
  parameter int FW = 12,
  parameter int NW = 36
) (
  input  logic [FW-1:0] cand_rem,
  input  logic [NW-1:0] cand_quo,
  input  logic [FW-1:0] best_rem,
  output logic          take
);

  always_comb begin
    take = (cand_rem < best_rem) && (cand_quo < NW'(FB_LIMIT));
  end

endmodule

// File: rtl/pll_divider_search.sv
module pll_divider_search
  import pds_pkg::*;
#(
  parameter int FW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [FW-1:0]   ref_mhz,
  input  logic [FW-1:0]   target_mhz,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [FW-1:0]   prediv_val,
  output logic [2*FW-1:0] fbdiv_val,
  output logic [3*FW-1:0] achieved_mhz,
  output logic [7:0]      prediv_code,
  output logic [7:0]      fb_lo_code,
  output logic [7:0]      fb_hi_code
);

  localparam int PW = 2 * FW;
  localparam int NW = 3 * FW;

  function automatic logic [7:0] f_pre_code(input logic [FW-1:0] p);
    logic [FW-1:0] t;
    t = p - FW'(1);
    return 8'(t);
  endfunction

  function automatic logic [7:0] f_lo_code(input logic [PW-1:0] f);
    logic [PW-1:0] t;
    t = f - PW'(1);
    return {3'b000, 5'(t)};
  endfunction

  function automatic logic [7:0] f_hi_code(input logic [PW-1:0] f);
    logic [PW-1:0] t;
    t = f - PW'(1);
    return 8'(t >> 5) | HI_FLAG;
  endfunction

  pds_state_e    st_q;
  logic [FW-1:0] ref_q, tgt_q;
  logic [FW-1:0] idx_q, end_q, best_q, pre_q;
  logic [PW-1:0] fb_q;
  logic [NW-1:0] ach_q;
  logic          err_q, done_q;
  logic [7:0]    pc_q, lo_q, hi_q;
  logic          go_q;
  logic [NW-1:0] dvd_q;
  logic [FW-1:0] dvs_q;

  logic [FW-1:0] win_lo, win_hi;
  logic          win_bad;
  logic          dv_valid;
  logic [NW-1:0] dv_quo;
  logic [FW-1:0] dv_rem;
  logic          take_w;

  // Named event: a candidate replaces the best so far
  logic          scan_take;

  pds_window #(.FW(FW)) i_window (
    .ref_in (ref_q),
    .pre_lo (win_lo),
    .pre_hi (win_hi),
    .bad    (win_bad)
  );

  pds_iter_div #(.N_W(NW), .D_W(FW)) i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go_q),
    .dividend (dvd_q),
    .divisor  (dvs_q),
    .valid    (dv_valid),
    .quo      (dv_quo),
    .rem      (dv_rem)
  );

  pds_judge #(.FW(FW), .NW(NW)) i_judge (
    .cand_rem (dv_rem),
    .cand_quo (dv_quo),
    .best_rem (best_q),
    .take     (take_w)
  );

  assign scan_take = (st_q == ST_SWAIT) && dv_valid && take_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ref_q  <= '0;
      tgt_q  <= '0;
      idx_q  <= '0;
      end_q  <= '0;
      best_q <= '0;
      pre_q  <= '0;
      fb_q   <= '0;
      ach_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      pc_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      go_q   <= 1'b0;
      dvd_q  <= '0;
      dvs_q  <= '0;
    end else begin
      go_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            ref_q  <= ref_mhz;
            tgt_q  <= target_mhz;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            st_q   <= ST_WIN;
          end
        end
        ST_WIN: begin
          if (win_bad) begin
            err_q <= 1'b1;
            pre_q <= '0;
            fb_q  <= '0;
            ach_q <= '0;
            st_q  <= ST_FIN;
          end else begin
            idx_q  <= win_lo;
            end_q  <= win_hi;
            best_q <= ref_q;
            pre_q  <= FW'(1);
            st_q   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          go_q  <= 1'b1;
          dvs_q <= ref_q;
          if (idx_q < end_q) begin
            dvd_q <= NW'(tgt_q) * NW'(idx_q);
            st_q  <= ST_SWAIT;
          end else begin
            dvd_q <= NW'(tgt_q) * NW'(pre_q);
            st_q  <= ST_FWAIT;
          end
        end
        ST_SWAIT: begin
          if (dv_valid) begin
            if (take_w) begin
              best_q <= dv_rem;
              pre_q  <= idx_q;
            end
            idx_q <= idx_q + FW'(1);
            st_q  <= ST_SCAN;
          end
        end
        ST_FWAIT: begin
          if (dv_valid) begin
            fb_q  <= PW'(dv_quo);
            go_q  <= 1'b1;
            dvd_q <= NW'(ref_q) * NW'(PW'(dv_quo));
            dvs_q <= pre_q;
            st_q  <= ST_AWAIT;
          end
        end
        ST_AWAIT: begin
          if (dv_valid) begin
            ach_q <= dv_quo;
            st_q  <= ST_FIN;
          end
        end
        ST_FIN: begin
          if (err_q) begin
            pc_q <= '0;
            lo_q <= '0;
            hi_q <= '0;
          end else begin
            pc_q <= f_pre_code(pre_q);
            lo_q <= f_lo_code(fb_q);
            hi_q <= f_hi_code(fb_q);
          end
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (st_q != ST_IDLE);
  assign done         = done_q;
  assign err          = err_q;
  assign prediv_val   = pre_q;
  assign fbdiv_val    = fb_q;
  assign achieved_mhz = ach_q;
  assign prediv_code  = pc_q;
  assign fb_lo_code   = lo_q;
  assign fb_hi_code   = hi_q;

endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
  parameter int FW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic [FW-1:0]   prediv_val,
  input logic [2*FW-1:0] fbdiv_val,
  input logic [3*FW-1:0] achieved_mhz,
  input logic [7:0]      prediv_code,
  input logic [7:0]      fb_lo_code,
  input logic [7:0]      fb_hi_code,
  input logic            scan_take,
  input logic [FW-1:0]   scan_idx,
  input logic [FW-1:0]   scan_end
);

  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(prediv_code) && $stable(fb_lo_code)
                          && $stable(fb_hi_code) && $stable(achieved_mhz)
                          && $stable(err)));

  p_err_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (prediv_val == '0 && fbdiv_val == '0 && achieved_mhz == '0
                       && prediv_code == 8'h00 && fb_lo_code == 8'h00
                       && fb_hi_code == 8'h00));

  p_hi_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> fb_hi_code[7]);

  p_lo_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_lo_code[7:5] == 3'b000);

  p_take_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_take |-> (scan_idx < scan_end));

  p_fb_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && prediv_val != FW'(1)) |-> (fbdiv_val < (2*FW)'(512)));

  p_reset_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done && !err));

endmodule

bind pll_divider_search pds_checker #(.FW(FW)) i_pds_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .prediv_val   (prediv_val),
  .fbdiv_val    (fbdiv_val),
  .achieved_mhz (achieved_mhz),
  .prediv_code  (prediv_code),
  .fb_lo_code   (fb_lo_code),
  .fb_hi_code   (fb_hi_code),
  .scan_take    (scan_take),
  .scan_idx     (idx_q),
  .scan_end     (end_q)
);

// File: tb/test_pll_divider_search.sv
`timescale 1ns/1ps
module test_pll_divider_search;

  localparam int FW = 12;
  localparam int RUN_LIMIT = 60000;
  localparam int TOTAL_LIMIT = 190000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [FW-1:0]   ref_mhz = '0;
  logic [FW-1:0]   target_mhz = '0;
  logic            busy, done, err;
  logic [FW-1:0]   prediv_val;
  logic [2*FW-1:0] fbdiv_val;
  logic [3*FW-1:0] achieved_mhz;
  logic [7:0]      prediv_code, fb_lo_code, fb_hi_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  pll_divider_search #(.FW(FW)) i_pll_divider_search (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .ref_mhz      (ref_mhz),
    .target_mhz   (target_mhz),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .prediv_val   (prediv_val),
    .fbdiv_val    (fbdiv_val),
    .achieved_mhz (achieved_mhz),
    .prediv_code  (prediv_code),
    .fb_lo_code   (fb_lo_code),
    .fb_hi_code   (fb_hi_code)
  );

  task automatic check_eq(input string req, input string what,
                          input longint unsigned act, input longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Behavioural model of the search, written from the requirements
  function automatic void ref_model(input longint rf, input longint tg,
      output bit e_err, output longint e_pre, output longint e_fb,
      output longint e_ach, output longint e_pc, output longint e_lo,
      output longint e_hi);
    longint hi_b, lo_b, best, t;
    hi_b = rf / 5;
    lo_b = (rf < 40) ? 1 : rf / 40 + 1;
    if (hi_b < lo_b) begin
      e_err = 1'b1;
      e_pre = 0; e_fb = 0; e_ach = 0; e_pc = 0; e_lo = 0; e_hi = 0;
      return;
    end
    e_err = 1'b0;
    e_pre = 1;
    best  = rf;
    for (longint i = lo_b; i < hi_b; i++) begin
      if (((tg * i) % rf) < best && ((tg * i) / rf) < 512) begin
        e_pre = i;
        best  = (tg * i) % rf;
      end
    end
    e_fb  = (tg * e_pre) / rf;
    e_ach = (rf * e_fb) / e_pre;
    e_pc  = (e_pre - 1) & 255;
    t     = (e_fb - 1) & ((longint'(1) << (2 * FW)) - 1);
    e_lo  = t & 31;
    e_hi  = ((t >> 5) & 255) | 128;
  endfunction

  task automatic run_case(input int rf, input int tg, input bit poke, input string req_pre);
    bit e_err;
    longint e_pre, e_fb, e_ach, e_pc, e_lo, e_hi;
    int cyc;
    ref_model(rf, tg, e_err, e_pre, e_fb, e_ach, e_pc, e_lo, e_hi);
    @(negedge clk);
    ref_mhz    = FW'(rf);
    target_mhz = FW'(tg);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7: inputs change after launch; result must not follow them
    ref_mhz    = FW'(rf + 7);
    target_mhz = FW'(tg + 3);
    check_eq("R7", "busy after start", busy, 1);
    check_eq("R7", "done cleared by start", done, 0);
    cyc = 0;
    while (!done && cyc < RUN_LIMIT) begin
      check_eq("R7", "busy while running", busy, 1);
      start = (poke && cyc == 5);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog: run ref=%0d target=%0d actual 0 expected 1 (done)", rf, tg);
      return;
    end
    check_eq("R7", "busy low at done", busy, 0);
    check_eq("R2", "err", err, e_err);
    check_eq(req_pre, "prediv", prediv_val, e_pre);
    check_eq("R5", "fbdiv", fbdiv_val, e_fb);
    check_eq("R5", "achieved", achieved_mhz, e_ach);
    check_eq("R6", "prediv code", prediv_code, e_pc);
    check_eq("R6", "fb low code", fb_lo_code, e_lo);
    check_eq("R6", "fb high code", fb_hi_code, e_hi);
    if (!e_err && e_pre != 1) begin
      // R1: chosen pre-divider lies in the window
      check_eq("R1", "prediv within window",
               (e_pre >= ((rf < 40) ? 1 : rf / 40 + 1)) && (e_pre < rf / 5), 1);
    end
    for (int k = 0; k < 3; k++) begin
      ref_mhz    = FW'(rf + k + 11);
      target_mhz = FW'(tg + k + 5);
      @(negedge clk);
      check_eq("R7", "done held", done, 1);
      check_eq("R7", "code held", prediv_code, e_pc);
      check_eq("R7", "achieved held", achieved_mhz, e_ach);
    end
  endtask

  initial begin
    #(TOTAL_LIMIT * 8);
    n_bad++;
    $display("FAIL watchdog: global time limit reached, actual running expected finished");
    finish_run();
  end

  initial begin
    int unsigned seed;
    int rr, tt;
    repeat (3) @(negedge clk);
    check_eq("R8", "busy in reset", busy, 0);
    check_eq("R8", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R8", "busy after reset", busy, 0);
    check_eq("R8", "done after reset", done, 0);
    check_eq("R8", "err after reset", err, 0);
    check_eq("R8", "codes after reset", {prediv_code, fb_lo_code, fb_hi_code}, 0);
    check_eq("R8", "achieved after reset", achieved_mhz, 0);

    run_case(24, 1000, 1'b0, "R3");   // exact division found late in window
    run_case(4, 500, 1'b0, "R2");     // R1/R2: upper bound 0 below lower bound 1
    run_case(0, 100, 1'b0, "R2");     // R2: zero reference
    run_case(5, 600, 1'b0, "R4");     // R4: window [1,1) is empty
    run_case(15, 4000, 1'b0, "R4");   // R3/R4: better remainder rejected by 512 limit
    run_case(30, 30, 1'b0, "R3");     // R3: ties keep smaller pre-divider
    run_case(40, 1234, 1'b1, "R3");   // R1 lower bound 2; R7 start poke mid-run
    run_case(100, 1500, 1'b0, "R3");  // R1 window [3,20)
    run_case(27, 1111, 1'b1, "R3");
    run_case(4095, 1, 1'b0, "R3");    // R6: fbdiv 0 forces wrapped codes
    seed = 32'h1234_5678;
    for (int n = 0; n < 8; n++) begin
      seed = seed * 1103515245 + 12345;
      rr = 1 + int'((seed >> 16) % 200);
      seed = seed * 1103515245 + 12345;
      tt = 1 + int'((seed >> 8) % 4095);
      run_case(rr, tt, n[0], "R3");
    end
    finish_run();
  end

endmodule